// File: doc/BRIEF.md
# Packed Decimal Adder with Add-Six Correction

This block adds two unsigned packed-decimal operands, each a row of 4-bit decimal digits, together with a one-bit carry-in. It returns a packed-decimal sum of the same width and a decimal carry out. With the default two digits, 99 + 99 gives a sum of 98 and a carry out of 1, which reads as 198.

Every digit position is its own slice with two stages. The first stage is a plain 4-bit binary adder. It adds the two operand digits and the decimal carry from the slice below. A small detector looks at that raw result. If the raw result went past nine, or the binary adder carried out, the detector raises a correction flag. The second stage then adds six to the raw result. Without the flag it adds zero. The flag is also the decimal carry into the next slice, and the flag of the top slice is the carry out of the block.

The arithmetic is purely combinational. A parameter selects whether a register follows it. By default the register is present: the result then appears one clock after the operands are sampled, and an active-low asynchronous reset clears it. Operand digits coded 1010 to 1111 are outside the contract, and the block's response to them is undefined.

Top module: `bcd_adder_top`

## Requirements
- R1: Digit codes 0000 to 1001 stand for the values 0 to 9. When every operand digit is valid, every result digit is one of these codes.
- R2: Each slice first forms the binary sum of its two operand digits and its incoming decimal carry. For two nines plus a carry this raw sum can reach 19.
- R3: A slice applies its correction when the raw sum is 10 to 15 or when the first-stage adder carried out. It then adds binary 0110 to the raw sum, and otherwise it adds 0000. A digit sum of 9 is left unchanged and a digit sum of 10 becomes digit 0.
- R4: The decimal carry out of each slice feeds the carry-in of the slice above it, and the top slice's carry is `carry_out`. For example, 45 + 55 gives 00 with `carry_out` = 1.
- R5: `carry_in` enters the least significant slice and adds one to the total.
- R6: For all valid operands, `carry_out` × 10^NUM_DIGITS + value(`sum_out`) equals value(`op_a`) + value(`op_b`) + `carry_in`.
- R7: 99 + 99 yields `sum_out` = 0x98 with `carry_out` = 1, and 99 + 66 yields 0x65 with `carry_out` = 1.
- R8: When REG_OUT = 1 (the default), the outputs change only on a rising clock edge and show the result for the inputs present at that edge. While `rst_n` is low, both outputs are 0.
- R9: Digit i of every operand and of the result sits in bits [4i+3:4i], so the least significant decimal digit is in bits [3:0].
- R10: The largest case, 99 + 99 with `carry_in` = 1, yields 0x99 with `carry_out` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| op_a | input | 4*NUM_DIGITS (8) | First packed-decimal operand |
| op_b | input | 4*NUM_DIGITS (8) | Second packed-decimal operand |
| carry_in | input | 1 | Decimal carry into the least significant digit |
| sum_out | output | 4*NUM_DIGITS (8) | Packed-decimal sum |
| carry_out | output | 1 | Decimal carry out of the most significant digit |

## Verification
The bench aims at the boundary between raw digit sums of 9 and 10. A detector that misses the S3·S2 or S3·S1 term lets codes 1010 to 1111 escape, and one that fires too early corrupts sums such as 5 + 4. It also aims at raw sums of 16 to 19, where only the binary carry reveals the overflow. A design that ignores that carry returns digits 0 to 3 with no carry into the next slice, so 9 + 9 would read as 2 instead of 18. Chains such as 45 + 55 and 99 + 99 + 1 catch a broken or misrouted decimal carry between slices. Every operand pair is swept with both carry-in values, and a check just before the clock edge catches a register that is bypassed or skewed by a cycle.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;

    // width of one decimal digit code
    localparam int DIGIT_W   = 4;
    // largest legal digit value
    localparam int DIGIT_MAX = 9;

    typedef logic [DIGIT_W-1:0] bcd_digit_t;

    // result of one digit slice
    typedef struct packed {
        bcd_digit_t digit;
        logic       dcarry;
    } slice_res_t;

endpackage

// File: rtl/ripple_add.sv
// First-stage binary adder: W-bit ripple of full adders with carry out.
module ripple_add #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         co
);

    logic [W:0] c;

    assign c[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign s[i]   = x[i] ^ y[i] ^ c[i];
        assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
    end

    assign co = c[W];

endmodule

// File: rtl/fix_add.sv
// Second-stage adder: W-bit ripple with carry-in 0 whose final carry is
// dropped, so only the low W bits of the corrected digit are kept.
module fix_add #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s
);

    logic [W-1:0] c;

    assign c[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign s[i] = x[i] ^ y[i] ^ c[i];
        if (i < W - 1) begin : g_carry
            assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
        end
    end

endmodule

// File: rtl/bcd_digit_slice.sv
// One decimal digit: binary add, out-of-range detector, add-six correction.
module bcd_digit_slice
    import bcd_add_pkg::*;
(
    input  bcd_digit_t a_dig,
    input  bcd_digit_t b_dig,
    input  logic       dcarry_in,
    output slice_res_t res
);

    bcd_digit_t raw_sum;
    logic       raw_co;
    logic       fix_flag;
    bcd_digit_t fix_operand;
    bcd_digit_t fixed_sum;

    ripple_add #(.W(DIGIT_W)) u_stage1 (
        .x   (a_dig),
        .y   (b_dig),
        .cin (dcarry_in),
        .s   (raw_sum),
        .co  (raw_co)
    );

    // flag raw sums of 10..15 (bit 3 with bit 2 or bit 1) and 16..19 (carry)
    assign fix_flag = raw_co | (raw_sum[3] & (raw_sum[2] | raw_sum[1]));

    // correction operand is 0110 when flagged, 0000 otherwise
    assign fix_operand = {1'b0, fix_flag, fix_flag, 1'b0};

    fix_add #(.W(DIGIT_W)) u_stage2 (
        .x (raw_sum),
        .y (fix_operand),
        .s (fixed_sum)
    );

    assign res.digit  = fixed_sum;
    assign res.dcarry = fix_flag;

endmodule

// File: rtl/bcd_adder_top.sv
module bcd_adder_top
    import bcd_add_pkg::*;
#(
    parameter int NUM_DIGITS = 2,
    parameter bit REG_OUT    = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DIGIT_W*NUM_DIGITS-1:0] op_a,
    input  logic [DIGIT_W*NUM_DIGITS-1:0] op_b,
    input  logic                          carry_in,
    output logic [DIGIT_W*NUM_DIGITS-1:0] sum_out,
    output logic                          carry_out
);

    localparam int VEC_W = DIGIT_W * NUM_DIGITS;

    // carry_chain[i] enters digit i; carry_chain[NUM_DIGITS] leaves the top
    logic [NUM_DIGITS:0] carry_chain;
    logic [VEC_W-1:0]    sum_comb;
    slice_res_t          slice_res [NUM_DIGITS];

    assign carry_chain[0] = carry_in;

    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
        bcd_digit_slice u_slice (
            .a_dig     (op_a[d*DIGIT_W +: DIGIT_W]),
            .b_dig     (op_b[d*DIGIT_W +: DIGIT_W]),
            .dcarry_in (carry_chain[d]),
            .res       (slice_res[d])
        );
        assign sum_comb[d*DIGIT_W +: DIGIT_W] = slice_res[d].digit;
        assign carry_chain[d+1]               = slice_res[d].dcarry;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sum_out   <= '0;
                carry_out <= 1'b0;
            end else begin
                sum_out   <= sum_comb;
                carry_out <= carry_chain[NUM_DIGITS];
            end
        end
    end else begin : g_comb
        assign sum_out   = sum_comb;
        assign carry_out = carry_chain[NUM_DIGITS];
    end

endmodule

// File: rtl/bcd_adder_chk.sv
module bcd_adder_chk #(
    parameter int NUM_DIGITS = 2,
    parameter bit REG_OUT    = 1'b1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [4*NUM_DIGITS-1:0] op_a,
    input logic [4*NUM_DIGITS-1:0] op_b,
    input logic                    carry_in,
    input logic [4*NUM_DIGITS-1:0] sum_out,
    input logic                    carry_out
);

    function automatic bit digits_ok(input logic [4*NUM_DIGITS-1:0] v);
        bit ok = 1'b1;
        for (int i = 0; i < NUM_DIGITS; i++)
            if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    function automatic longint dec_val(input logic [4*NUM_DIGITS-1:0] v);
        longint acc = 0;
        for (int i = NUM_DIGITS - 1; i >= 0; i--)
            acc = acc * 10 + longint'(v[i*4 +: 4]);
        return acc;
    endfunction

    function automatic longint ten_pow();
        longint p = 1;
        for (int i = 0; i < NUM_DIGITS; i++) p = p * 10;
        return p;
    endfunction

    localparam logic [4*NUM_DIGITS-1:0] ALL_NINE = {NUM_DIGITS{4'd9}};

    longint in_total;
    logic   in_valid;
    logic   in_nines;
    longint out_total;

    always_comb begin
        in_total  = dec_val(op_a) + dec_val(op_b) + longint'(carry_in);
        in_valid  = digits_ok(op_a) && digits_ok(op_b);
        in_nines  = (op_a == ALL_NINE) && (op_b == ALL_NINE);
        out_total = dec_val(sum_out) + (carry_out ? ten_pow() : 64'sd0);
    end

    longint ref_total;
    logic   ref_valid;
    logic   ref_nines;
    logic   armed;

    if (REG_OUT) begin : g_lat1
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ref_total <= 0;
                ref_valid <= 1'b0;
                ref_nines <= 1'b0;
                armed     <= 1'b0;
            end else begin
                ref_total <= in_total;
                ref_valid <= in_valid;
                ref_nines <= in_nines;
                armed     <= 1'b1;
            end
        end

        logic [1:0] rst_cnt;
        always_ff @(posedge clk) begin
            if (rst_n)                rst_cnt <= 2'd0;
            else if (rst_cnt != 2'd3) rst_cnt <= rst_cnt + 2'd1;
        end

        // R8: outputs held at zero during reset
        a_r8_reset_zero: assert property (@(posedge clk)
            (rst_cnt >= 2'd2) |-> (sum_out == '0 && !carry_out));
    end else begin : g_lat0
        always_comb begin
            ref_total = in_total;
            ref_valid = in_valid;
            ref_nines = in_nines;
            armed     = 1'b1;
        end
    end

    // R6: output total equals the decimal sum of the operands
    a_r6_total: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ref_valid) |-> (out_total == ref_total));

    // R1: result digits are legal codes
    a_r1_digit_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ref_valid) |-> digits_ok(sum_out));

    // R4: carry out set exactly when the total reaches 10^NUM_DIGITS
    a_r4_carry_out: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ref_valid) |-> (carry_out == (ref_total >= ten_pow())));

    // R7: all-nine operands always carry out
    a_r7_nines_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ref_nines) |-> carry_out);

endmodule

bind bcd_adder_top bcd_adder_chk #(
    .NUM_DIGITS (NUM_DIGITS),
    .REG_OUT    (REG_OUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out)
);

// File: tb/tb_bcd_adder_top.sv
`timescale 1ns/1ps
module tb_bcd_adder_top;

    localparam int ND = 2;
    localparam int VW = 4 * ND;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] op_a = '0;
    logic [VW-1:0] op_b = '0;
    logic          carry_in = 1'b0;
    logic [VW-1:0] sum_out;
    logic          carry_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bcd_adder_top #(.NUM_DIGITS(ND), .REG_OUT(1'b1)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    // decimal value to packed digits, least significant digit in bits [3:0]
    function automatic logic [VW-1:0] to_bcd(input int v);
        logic [VW-1:0] r = '0;
        int t = v;
        for (int i = 0; i < ND; i++) begin
            r[i*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    // {a, b, cin}; expected result worked out from the integer sum
    localparam int NVEC = 11;
    localparam int VEC [NVEC][3] = '{
        '{99, 99, 0},   // R7 198
        '{99, 66, 0},   // R7 165
        '{ 5,  4, 0},   // R3 digit 9, no correction
        '{ 5,  5, 0},   // R3 digit 10 corrected to 0
        '{ 9,  9, 1},   // R2 raw 19, binary carry path
        '{ 8,  1, 1},   // R5 carry-in pushes 9 to 10
        '{45, 55, 0},   // R4 carry ripples through both digits
        '{99, 99, 1},   // R10 largest total
        '{ 3, 40, 0},   // R9 digit placement
        '{ 0,  0, 1},   // R5 carry-in alone
        '{ 7,  8, 0}    // R3 raw 15 corrected
    };
    localparam string VTAG [NVEC] = '{"R7", "R7", "R3", "R3", "R2", "R5",
                                      "R4", "R10", "R9", "R5", "R3"};

    task automatic check_out(input logic [VW-1:0] exp_s, input logic exp_c,
                             input string tag);
        checks++;
        if (sum_out !== exp_s || carry_out !== exp_c) begin
            errors++;
            $display("FAIL %s: got carry=%0b sum=%h, expected carry=%0b sum=%h",
                     tag, carry_out, sum_out, exp_c, exp_s);
        end
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic run_add(input int a, input int b, input bit ci, input string tag);
        int tot = a + b + int'(ci);
        op_a     = to_bcd(a);
        op_b     = to_bcd(b);
        carry_in = ci;
        @(negedge clk);
        check_out(to_bcd(tot % 100), tot >= 100, tag);
    endtask

    initial begin
        // R8: reset state
        @(negedge clk);
        @(negedge clk);
        check_out('0, 1'b0, "R8 reset");
        op_a = to_bcd(99);
        op_b = to_bcd(99);
        @(negedge clk);
        check_out('0, 1'b0, "R8 held in reset");
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++)
            run_add(VEC[v][0], VEC[v][1], VEC[v][2] != 0, VTAG[v]);

        // R8: no change before the clock edge
        run_add(12, 34, 1'b0, "R8 settle");
        op_a = to_bcd(50);
        op_b = to_bcd(50);
        #1;
        check_out(to_bcd(46), 1'b0, "R8 before edge");
        @(negedge clk);
        check_out(to_bcd(0), 1'b1, "R8 after edge");

        // R6 R1: full sweep of operand pairs and both carry-in values
        for (int ci = 0; ci < 2; ci++)
            for (int a = 0; a < 100; a++)
                for (int b = 0; b < 100; b++)
                    run_add(a, b, ci[0], "R6");

        // R8: reset clears a live result
        run_add(77, 88, 1'b1, "R8 pre-reset");
        #1 rst_n = 1'b0;
        #1;
        check_out('0, 1'b0, "R8 async clear");
        @(negedge clk);
        rst_n = 1'b1;
        run_add(99, 66, 1'b0, "R7 after reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule